// File: doc/BRIEF.md
# CAN Mailbox Transmit Abort Controller

This block keeps the 4-bit code field and the completion flag of every mailbox in a bank of CAN transmit mailboxes, and it decides what happens when software asks to withdraw a frame. A CPU write port updates one mailbox code per cycle. A global enable bit turns the abort feature on. The transmit engine reports which mailbox it holds (on the bus or already copied into the serial shift buffer) and sends one-cycle strobes for arbitration loss, transmit error, freeze-mode entry and successful completion.

An abort aimed at an idle active mailbox takes effect on the next clock. An abort aimed at the mailbox the engine holds is not refused. The block blocks the code write and keeps the request pending. The request then resolves in one of two ways: it becomes an abort if the frame loses arbitration, hits an error or the module freezes, or it becomes a normal send if the frame completes. Either way the mailbox flag rises. The flags are write-one-to-clear, and a single interrupt line merges the flags through a per-mailbox mask.

Each mailbox runs a small state machine with three states. MB_IDLE means the code is not an active transmit code. MB_ACTIVE means the mailbox holds code 4'b1100 with no abort waiting. MB_PEND means the mailbox holds 4'b1100 and an abort is latched. The transitions are:
- T_LOAD (MB_IDLE to MB_ACTIVE): a write of 4'b1100.
- T_ABORT_NOW (MB_ACTIVE to MB_IDLE): an enabled abort while the engine does not hold the mailbox.
- T_HOLD (MB_ACTIVE to MB_PEND): an enabled abort while the engine holds the mailbox.
- T_SENT (MB_ACTIVE or MB_PEND to MB_IDLE): completion.
- T_ABORTED (MB_PEND to MB_IDLE): arbitration loss, error or freeze.
- T_DEACT (MB_ACTIVE to MB_IDLE): a plain code write while aborts are disabled.

Top module: `can_tx_abort_ctrl`

## Requirements
- R1: With abort_en low, a write of 4'b1001 to a mailbox is an ordinary code write. On the next clock the code reads 4'b1001 and the mailbox flag stays low.
- R2: With abort_en high, a write of 4'b1001 to a mailbox whose code is 4'b1100 and that the engine does not hold changes the code to 4'b1001 and sets its flag, both visible one clock later.
- R3: With abort_en high, a write of 4'b1001 to a 4'b1100 mailbox that the engine holds (tx_busy high and tx_idx equal to it) is blocked. The code stays 4'b1100, the flag stays low, and an abort is latched as pending.
- R4: A pending abort resolves when ev_arb_lost or ev_tx_err pulses while the engine holds that mailbox. One clock later the code is 4'b1001 and the flag is set. Without a pending abort these strobes leave code and flag unchanged.
- R5: ev_freeze resolves every pending abort in the bank the same way: code 4'b1001 and the flag set one clock later, whether or not the engine holds the mailbox.
- R6: ev_tx_done while the engine holds a 4'b1100 mailbox sets its code to 4'b1000 (inactive transmit) and sets its flag one clock later. Any pending abort for that mailbox is cleared at the same moment.
- R7: If ev_tx_done and ev_arb_lost or ev_tx_err arrive in the same cycle for a mailbox with a pending abort, completion wins and the code becomes 4'b1000.
- R8: With abort_en high, writes of any other code to a 4'b1100 mailbox, and all writes to a mailbox with a pending abort, are ignored. Writes to a mailbox whose code is not 4'b1100 always take effect.
- R9: A 1 in bit k of flag_clr clears flag k one clock later. If the flag sets in the same cycle, the set wins.
- R10: irq is high exactly when some flag k and int_mask bit k are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_en | input | 1 | Global enable of the abort feature |
| wr_en | input | 1 | Code-field write strobe |
| wr_idx | input | IDX_W | Mailbox selected by the write |
| wr_code | input | 4 | Code value written |
| flag_clr | input | NUM_MB | Write-one-to-clear for the flags |
| int_mask | input | NUM_MB | Per-mailbox interrupt mask |
| tx_busy | input | 1 | Engine holds a mailbox (on the bus or in the shift buffer) |
| tx_idx | input | IDX_W | Mailbox the engine holds |
| ev_arb_lost | input | 1 | Arbitration lost on the held frame |
| ev_tx_err | input | 1 | Error while sending the held frame |
| ev_freeze | input | 1 | Module enters freeze mode |
| ev_tx_done | input | 1 | Held frame sent successfully |
| code_out | output | 4*NUM_MB | Code fields; mailbox k occupies bits 4k+3..4k |
| iflag | output | NUM_MB | Per-mailbox completion flags |
| irq | output | 1 | Masked OR of the flags |

## Verification
The hardest state to reach is MB_PEND. From the ports it looks exactly like MB_ACTIVE, because both read 4'b1100. The only evidence that the state exists is how the mailbox reacts to a later strobe. For every mailbox, the bench holds that mailbox on the engine, issues the abort, and confirms that the code did not change. It then drives one of the resolving events in turn: arbitration loss, error, freeze, completion, and completion together with loss. After a completion it reloads the mailbox and pulses an arbitration loss to show that the earlier request was cleared.

// File: rtl/can_abort_pkg.sv
package can_abort_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_TX_INACT  = 4'b1000;
    localparam logic [CODE_W-1:0] CODE_TX_ACTIVE = 4'b1100;
    localparam logic [CODE_W-1:0] CODE_TX_ABORT  = 4'b1001;
    localparam logic [CODE_W-1:0] CODE_RESET     = 4'b0000;

    typedef enum logic [1:0] {
        MB_IDLE   = 2'd0,
        MB_ACTIVE = 2'd1,
        MB_PEND   = 2'd2
    } mb_state_e;

endpackage

// File: rtl/can_mb_slot.sv
module can_mb_slot
    import can_abort_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_en,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              on_engine,
    input  logic              ev_done,
    input  logic              ev_fail,
    input  logic              ev_freeze,
    input  logic              flag_clr,
    output logic [CODE_W-1:0] code,
    output logic              flag
);

    mb_state_e         state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic              flag_q, flag_set;

    // State register together with the code and flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MB_IDLE;
            code_q  <= CODE_RESET;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            if (flag_set)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        code_d   = code_q;
        flag_set = 1'b0;
        unique case (state_q)
            MB_IDLE: begin
                if (wr_hit) begin
                    code_d = wr_code;
                    if (wr_code == CODE_TX_ACTIVE)
                        state_d = MB_ACTIVE;              // T_LOAD
                end
            end
            MB_ACTIVE: begin
                if (on_engine && ev_done) begin
                    code_d   = CODE_TX_INACT;             // T_SENT
                    flag_set = 1'b1;
                    state_d  = MB_IDLE;
                end else if (wr_hit) begin
                    if (abort_en) begin
                        if (wr_code == CODE_TX_ABORT) begin
                            if (on_engine) begin
                                state_d = MB_PEND;        // T_HOLD
                            end else begin
                                code_d   = CODE_TX_ABORT; // T_ABORT_NOW
                                flag_set = 1'b1;
                                state_d  = MB_IDLE;
                            end
                        end
                    end else begin
                        code_d = wr_code;
                        if (wr_code != CODE_TX_ACTIVE)
                            state_d = MB_IDLE;            // T_DEACT
                    end
                end
            end
            MB_PEND: begin
                if (on_engine && ev_done) begin
                    code_d   = CODE_TX_INACT;             // T_SENT
                    flag_set = 1'b1;
                    state_d  = MB_IDLE;
                end else if ((on_engine && ev_fail) || ev_freeze) begin
                    code_d   = CODE_TX_ABORT;             // T_ABORTED
                    flag_set = 1'b1;
                    state_d  = MB_IDLE;
                end
            end
            default: state_d = MB_IDLE;
        endcase
    end

    assign code = code_q;
    assign flag = flag_q;

endmodule

// File: rtl/can_irq_merge.sv
module can_irq_merge #(
    parameter int NUM_MB = 16
) (
    input  logic [NUM_MB-1:0] flags,
    input  logic [NUM_MB-1:0] mask,
    output logic              irq
);

    assign irq = |(flags & mask);

endmodule

// File: rtl/can_tx_abort_ctrl.sv
module can_tx_abort_ctrl
    import can_abort_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     abort_en,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [CODE_W-1:0]        wr_code,
    input  logic [NUM_MB-1:0]        flag_clr,
    input  logic [NUM_MB-1:0]        int_mask,
    input  logic                     tx_busy,
    input  logic [IDX_W-1:0]         tx_idx,
    input  logic                     ev_arb_lost,
    input  logic                     ev_tx_err,
    input  logic                     ev_freeze,
    input  logic                     ev_tx_done,
    output logic [NUM_MB*CODE_W-1:0] code_out,
    output logic [NUM_MB-1:0]        iflag,
    output logic                     irq
);

    logic ev_fail;
    assign ev_fail = ev_arb_lost | ev_tx_err;

    for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
        logic wr_hit, on_engine;
        assign wr_hit    = wr_en   && (wr_idx == IDX_W'(i));
        assign on_engine = tx_busy && (tx_idx == IDX_W'(i));

        can_mb_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .abort_en  (abort_en),
            .wr_hit    (wr_hit),
            .wr_code   (wr_code),
            .on_engine (on_engine),
            .ev_done   (ev_tx_done),
            .ev_fail   (ev_fail),
            .ev_freeze (ev_freeze),
            .flag_clr  (flag_clr[i]),
            .code      (code_out[i*CODE_W +: CODE_W]),
            .flag      (iflag[i])
        );
    end

    can_irq_merge #(.NUM_MB(NUM_MB)) u_irq (
        .flags (iflag),
        .mask  (int_mask),
        .irq   (irq)
    );

endmodule

// File: rtl/can_tx_abort_chk.sv
module can_tx_abort_chk #(
    parameter int NUM_MB = 16,
    parameter int IDX_W  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  abort_en,
    input logic                  wr_en,
    input logic [IDX_W-1:0]      wr_idx,
    input logic [3:0]            wr_code,
    input logic [NUM_MB-1:0]     flag_clr,
    input logic [NUM_MB-1:0]     int_mask,
    input logic                  tx_busy,
    input logic [IDX_W-1:0]      tx_idx,
    input logic                  ev_arb_lost,
    input logic                  ev_tx_err,
    input logic                  ev_freeze,
    input logic                  ev_tx_done,
    input logic [NUM_MB*4-1:0]   code_out,
    input logic [NUM_MB-1:0]     iflag,
    input logic                  irq
);

    p_irq_merge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(iflag & int_mask));

    for (genvar k = 0; k < NUM_MB; k++) begin : g_mb
        logic [3:0] cd;
        logic       held, wr_k;
        assign cd   = code_out[k*4 +: 4];
        assign held = tx_busy && (tx_idx == IDX_W'(k));
        assign wr_k = wr_en && (wr_idx == IDX_W'(k));

        p_no_flag_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_k && !abort_en && !held && !ev_freeze && !iflag[k])
            |=> !iflag[k]);

        p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_k && abort_en && wr_code == 4'b1001 && cd == 4'b1100 && held
             && !ev_tx_done && !ev_arb_lost && !ev_tx_err && !ev_freeze)
            |=> (cd == 4'b1100));

        p_success_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (held && ev_tx_done && cd == 4'b1100)
            |=> (cd == 4'b1000 && iflag[k]));

        p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[k] && !wr_en && !tx_busy && !ev_freeze)
            |=> !iflag[k]);
    end

endmodule

bind can_tx_abort_ctrl can_tx_abort_chk #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .abort_en(abort_en), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_code(wr_code), .flag_clr(flag_clr),
    .int_mask(int_mask), .tx_busy(tx_busy), .tx_idx(tx_idx),
    .ev_arb_lost(ev_arb_lost), .ev_tx_err(ev_tx_err), .ev_freeze(ev_freeze),
    .ev_tx_done(ev_tx_done), .code_out(code_out), .iflag(iflag), .irq(irq)
);

// File: tb/test_can_tx_abort_ctrl.sv
module test_can_tx_abort_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          abort_en = 1'b0, wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0, tx_idx = '0;
    logic [3:0]    wr_code = '0;
    logic [N-1:0]  flag_clr = '0, int_mask = '0;
    logic          tx_busy = 1'b0, ev_arb_lost = 1'b0, ev_tx_err = 1'b0;
    logic          ev_freeze = 1'b0, ev_tx_done = 1'b0;
    logic [N*4-1:0] code_out;
    logic [N-1:0]  iflag;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_tx_abort_ctrl #(.NUM_MB(N)) i_can_tx_abort_ctrl (
        .clk(clk), .rst_n(rst_n), .abort_en(abort_en), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_code(wr_code), .flag_clr(flag_clr),
        .int_mask(int_mask), .tx_busy(tx_busy), .tx_idx(tx_idx),
        .ev_arb_lost(ev_arb_lost), .ev_tx_err(ev_tx_err), .ev_freeze(ev_freeze),
        .ev_tx_done(ev_tx_done), .code_out(code_out), .iflag(iflag), .irq(irq)
    );

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [3:0] c);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_code = c;
        tick;
        wr_en = 1'b0;
    endtask

    function automatic int code_of(input int k);
        return int'(code_out[k*4 +: 4]);
    endfunction

    task automatic clear_all;
        flag_clr = '1;
        tick;
        flag_clr = '0;
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report;
    end

    initial begin
        repeat (3) tick;
        check("reset code", code_of(0), 0);
        check("R9 reset flags", int'(iflag), 0);
        check("R10 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        tick;

        for (int k = 0; k < N; k++) begin
            int s;
            s = k % 6;
            int_mask = (k % 2 == 0) ? '1 : '0;
            clear_all;

            // R1: abort code is a plain write when disabled
            abort_en = 1'b0;
            wr(k, 4'b1100);
            check("R8 load inactive", code_of(k), 12);
            wr(k, 4'b1001);
            check("R1 code", code_of(k), 9);
            check("R1 flag", int'(iflag[k]), 0);

            // R8: other writes to active mailbox ignored when enabled
            abort_en = 1'b1;
            wr(k, 4'b1100);
            wr(k, 4'b0011);
            check("R8 active blocked", code_of(k), 12);

            if (s == 0) begin
                wr(k, 4'b1001);
                check("R2 code", code_of(k), 9);
                check("R2 flag", int'(iflag[k]), 1);
                check("R10 irq", int'(irq), (k % 2 == 0) ? 1 : 0);
                flag_clr[k] = 1'b1; tick; flag_clr = '0;
                check("R9 clear", int'(iflag[k]), 0);
                check("R10 irq low", int'(irq), 0);
            end else begin
                tx_busy = 1'b1; tx_idx = IW'(k);
                if (s == 1) begin
                    ev_arb_lost = 1'b1; tick; ev_arb_lost = 1'b0;
                    check("R4 no pending code", code_of(k), 12);
                    check("R4 no pending flag", int'(iflag[k]), 0);
                end
                wr(k, 4'b1001);
                check("R3 code held", code_of(k), 12);
                check("R3 flag low", int'(iflag[k]), 0);
                wr(k, 4'b0011);
                check("R8 pending blocked", code_of(k), 12);
                if (s == 1 || s == 2) begin
                    if (s == 1) ev_arb_lost = 1'b1; else ev_tx_err = 1'b1;
                    tick;
                    ev_arb_lost = 1'b0; ev_tx_err = 1'b0;
                    check("R4 code", code_of(k), 9);
                    check("R4 flag", int'(iflag[k]), 1);
                end else if (s == 3) begin
                    tx_busy = 1'b0; ev_freeze = 1'b1; tick; ev_freeze = 1'b0;
                    check("R5 code", code_of(k), 9);
                    check("R5 flag", int'(iflag[k]), 1);
                end else if (s == 4) begin
                    ev_tx_done = 1'b1; tick; ev_tx_done = 1'b0;
                    check("R6 code", code_of(k), 8);
                    check("R6 flag", int'(iflag[k]), 1);
                    clear_all;
                    wr(k, 4'b1100);
                    ev_arb_lost = 1'b1; tick; ev_arb_lost = 1'b0;
                    check("R6 pending cleared code", code_of(k), 12);
                    check("R6 pending cleared flag", int'(iflag[k]), 0);
                end else begin
                    ev_tx_done = 1'b1; ev_arb_lost = 1'b1; flag_clr[k] = 1'b1;
                    tick;
                    ev_tx_done = 1'b0; ev_arb_lost = 1'b0; flag_clr = '0;
                    check("R7 code", code_of(k), 8);
                    check("R9 set wins", int'(iflag[k]), 1);
                end
                tx_busy = 1'b0;
                check("R10 irq", int'(irq), (int'(iflag[k]) == 1 && k % 2 == 0) ? 1 : 0);
            end
        end

        report;
    end

endmodule